// File: doc/BRIEF.md
# Oscillator Band Lock Search Controller

This controller finds a working oscillator and sub-band for a frequency synthesizer. The synthesizer has three oscillators with eight sub-bands each. The controller treats them as one ordered index of 24 settings, from the lowest frequency to the highest. A start pulse loads a starting index. The controller drives that setting and waits a programmable number of settle cycles. It then reads a 3-bit lock-detect code and decides whether to stop, step down or step up.

The search is steered by the code. A code in the middle range means the loop is locked, and the first such setting is kept. The all-zeros code means the oscillator sits at the bottom of its range, so the index moves one step lower. The all-ones code means it sits at the top, so the index moves one step higher. The search fails in two cases: a step would leave the index range, or the direction reverses, which means the loop is oscillating between two unlocked settings. A 2-bit output divider setting is captured at start and passed through unchanged.

Top module: `vco_band_search`

## Requirements
- R1: After reset, done_o, locked_o and fail_o are 0, the index is 0 (osc_sel_o=0, sub_sel_o=0) and div_sel_o is 2'b00.
- R2: A start_i pulse while idle loads start_idx_i and clears locked_o and fail_o. A start_idx_i above 23 is clamped to 23. The new setting appears on the outputs in the cycle after the start edge.
- R3: osc_sel_o equals the index divided by 8, and sub_sel_o equals the index modulo 8.
- R4: After each new setting, with settle_cycles_i = N latched at start (N may be 0), the lock code is evaluated at the (N+1)th clock edge. One decision therefore takes N+1 cycles.
- R5: A lock code from 3'b001 through 3'b110 ends the search. The current setting is kept, with locked_o=1 and fail_o=0.
- R6: A lock code of 3'b000 moves the index one step lower and starts a new settle wait.
- R7: A lock code of 3'b111 moves the index one step higher and starts a new settle wait.
- R8: If a step would go below 0 or above 23, the search ends with fail_o=1 and locked_o=0, and the index stays where it is.
- R9: A step in the opposite direction to the previous step ends the search with fail_o=1, and the index stays where it is.
- R10: done_o is high for exactly one cycle, the cycle after the deciding edge. locked_o and fail_o hold their values until the next accepted start.
- R11: start_i is ignored while a search is in progress.
- R12: div_sel_o takes div_sel_i at an accepted start and holds it until the next accepted start. The encoding is 00 = divide by 4, 01 = by 8, 10 = by 16, 11 = by 32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start a search when idle |
| start_idx_i | input | 5 | Starting combined index (0 to 23) |
| settle_cycles_i | input | 16 | Settle wait N, latched at start |
| div_sel_i | input | 2 | Output divider setting to pass through |
| lock_code_i | input | 3 | Lock-detect code from the synthesizer |
| osc_sel_o | output | 2 | Oscillator select |
| sub_sel_o | output | 3 | Sub-band select |
| div_sel_o | output | 2 | Latched divider setting |
| done_o | output | 1 | One-cycle end-of-search pulse |
| locked_o | output | 1 | Search ended in lock |
| fail_o | output | 1 | Search ended without lock |

## Verification
Each search ends at a known edge. A run of D decisions with settle value N places done_o at the D*(N+1)th edge after the start edge. The bench drives inputs on falling edges and counts the falling edges after start until done_o appears. It then compares that count with D*(N+1), where D comes from the lock-code model the bench applies. The new starting setting is checked one falling edge after the start edge. The done pulse and the held flags are checked one cycle later. A second start pulse is injected partway through one run, and the bench confirms that the run's timing and final index are unchanged.

// File: rtl/vbs_pkg.sv
package vbs_pkg;
    typedef enum logic [0:0] {ST_IDLE, ST_WAIT} state_e;
    typedef enum logic [1:0] {DIR_NONE, DIR_UP, DIR_DOWN} dir_e;
    typedef enum logic [1:0] {CODE_LOCK, CODE_LOW, CODE_HIGH} code_e;
endpackage

// File: rtl/vbs_code_class.sv
module vbs_code_class
    import vbs_pkg::*;
#(
    parameter int CODE_W = 3
) (
    input  logic [CODE_W-1:0] code_i,
    output code_e             class_o
);
    always_comb begin
        if (code_i == '0)       class_o = CODE_LOW;
        else if (&code_i)       class_o = CODE_HIGH;
        else                    class_o = CODE_LOCK;
    end
endmodule

// File: rtl/vbs_settle_timer.sv
module vbs_settle_timer #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [CNT_W-1:0] load_val_i,
    input  logic             run_i,
    output logic             expired_o
);
    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load_i)                     cnt_d = load_val_i;
        else if (run_i && cnt_q != '0)  cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign expired_o = (cnt_q == '0);
endmodule

// File: rtl/vbs_index_map.sv
module vbs_index_map #(
    parameter int SUBBANDS = 8,
    parameter int IDX_W    = 5,
    parameter int OSC_W    = 2,
    parameter int SUB_W    = 3
) (
    input  logic [IDX_W-1:0] idx_i,
    output logic [OSC_W-1:0] osc_o,
    output logic [SUB_W-1:0] sub_o
);
    generate
        if ((SUBBANDS & (SUBBANDS - 1)) == 0) begin : g_pow2
            assign osc_o = OSC_W'(idx_i >> SUB_W);
            assign sub_o = idx_i[SUB_W-1:0];
        end else begin : g_div
            assign osc_o = OSC_W'(idx_i / IDX_W'(SUBBANDS));
            assign sub_o = SUB_W'(idx_i % IDX_W'(SUBBANDS));
        end
    endgenerate
endmodule

// File: rtl/vco_band_search.sv
module vco_band_search
    import vbs_pkg::*;
#(
    parameter int NUM_OSC  = 3,
    parameter int SUBBANDS = 8,
    parameter int SETTLE_W = 16,
    parameter int CODE_W   = 3,
    parameter int DIV_W    = 2,
    localparam int NUM_IDX = NUM_OSC * SUBBANDS,
    localparam int IDX_W   = $clog2(NUM_IDX),
    localparam int OSC_W   = (NUM_OSC > 1) ? $clog2(NUM_OSC) : 1,
    localparam int SUB_W   = (SUBBANDS > 1) ? $clog2(SUBBANDS) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start_i,
    input  logic [IDX_W-1:0]    start_idx_i,
    input  logic [SETTLE_W-1:0] settle_cycles_i,
    input  logic [DIV_W-1:0]    div_sel_i,
    input  logic [CODE_W-1:0]   lock_code_i,
    output logic [OSC_W-1:0]    osc_sel_o,
    output logic [SUB_W-1:0]    sub_sel_o,
    output logic [DIV_W-1:0]    div_sel_o,
    output logic                done_o,
    output logic                locked_o,
    output logic                fail_o
);
    localparam logic [IDX_W-1:0] IDX_MAX = IDX_W'(NUM_IDX - 1);

    typedef struct packed {
        state_e              state;
        dir_e                dir;
        logic [IDX_W-1:0]    idx;
        logic [SETTLE_W-1:0] settle;
        logic [DIV_W-1:0]    div;
        logic                done;
        logic                locked;
        logic                fail;
    } regs_t;

    regs_t r_d, r_q;

    code_e               code_cls;
    logic                tmr_expired;
    logic                tmr_load;
    logic [SETTLE_W-1:0] tmr_val;
    logic                busy_w;

    vbs_code_class #(.CODE_W(CODE_W)) u_class (
        .code_i  (lock_code_i),
        .class_o (code_cls)
    );

    vbs_settle_timer #(.CNT_W(SETTLE_W)) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (tmr_load),
        .load_val_i (tmr_val),
        .run_i      (busy_w),
        .expired_o  (tmr_expired)
    );

    vbs_index_map #(
        .SUBBANDS (SUBBANDS),
        .IDX_W    (IDX_W),
        .OSC_W    (OSC_W),
        .SUB_W    (SUB_W)
    ) u_map (
        .idx_i (r_q.idx),
        .osc_o (osc_sel_o),
        .sub_o (sub_sel_o)
    );

    assign busy_w = (r_q.state == ST_WAIT);

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        tmr_load = 1'b0;
        tmr_val  = r_q.settle;
        case (r_q.state)
            ST_IDLE: begin
                if (start_i) begin
                    r_d.state  = ST_WAIT;
                    r_d.dir    = DIR_NONE;
                    r_d.idx    = (start_idx_i > IDX_MAX) ? IDX_MAX : start_idx_i;
                    r_d.settle = settle_cycles_i;
                    r_d.div    = div_sel_i;
                    r_d.locked = 1'b0;
                    r_d.fail   = 1'b0;
                    tmr_load   = 1'b1;
                    tmr_val    = settle_cycles_i;
                end
            end
            ST_WAIT: begin
                if (tmr_expired) begin
                    case (code_cls)
                        CODE_LOCK: begin
                            r_d.state  = ST_IDLE;
                            r_d.done   = 1'b1;
                            r_d.locked = 1'b1;
                        end
                        CODE_LOW: begin
                            if (r_q.idx == '0 || r_q.dir == DIR_UP) begin
                                r_d.state = ST_IDLE;
                                r_d.done  = 1'b1;
                                r_d.fail  = 1'b1;
                            end else begin
                                r_d.idx  = r_q.idx - 1'b1;
                                r_d.dir  = DIR_DOWN;
                                tmr_load = 1'b1;
                            end
                        end
                        default: begin
                            if (r_q.idx == IDX_MAX || r_q.dir == DIR_DOWN) begin
                                r_d.state = ST_IDLE;
                                r_d.done  = 1'b1;
                                r_d.fail  = 1'b1;
                            end else begin
                                r_d.idx  = r_q.idx + 1'b1;
                                r_d.dir  = DIR_UP;
                                tmr_load = 1'b1;
                            end
                        end
                    endcase
                end
            end
            default: r_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.state  <= ST_IDLE;
            r_q.dir    <= DIR_NONE;
            r_q.idx    <= '0;
            r_q.settle <= '0;
            r_q.div    <= '0;
            r_q.done   <= 1'b0;
            r_q.locked <= 1'b0;
            r_q.fail   <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign div_sel_o = r_q.div;
    assign done_o    = r_q.done;
    assign locked_o  = r_q.locked;
    assign fail_o    = r_q.fail;
endmodule

// File: rtl/vco_band_search_chk.sv
module vco_band_search_chk #(
    parameter int NUM_OSC  = 3,
    parameter int SUBBANDS = 8,
    parameter int OSC_W    = 2,
    parameter int SUB_W    = 3,
    parameter int DIV_W    = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic             busy,
    input logic             start_i,
    input logic [OSC_W-1:0] osc_sel_o,
    input logic [SUB_W-1:0] sub_sel_o,
    input logic [DIV_W-1:0] div_sel_o,
    input logic             done_o,
    input logic             locked_o,
    input logic             fail_o
);
    logic [15:0] idx_now;
    assign idx_now = 16'(osc_sel_o) * 16'(SUBBANDS) + 16'(sub_sel_o);

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o); // R10
    AST_FLAGS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start_i) |=> ($stable(locked_o) && $stable(fail_o))); // R10
    AST_LOCK_FAIL_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(locked_o && fail_o)); // R5
    AST_IDX_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (32'(osc_sel_o) < NUM_OSC) && (32'(sub_sel_o) < SUBBANDS)); // R3
    AST_ONE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> (idx_now == $past(idx_now) || idx_now == $past(idx_now) + 16'd1
                  || idx_now + 16'd1 == $past(idx_now))); // R6
    AST_DIV_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(div_sel_o)); // R12
    AST_FLAGS_CLEAR_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (!locked_o && !fail_o)); // R2
endmodule

bind vco_band_search vco_band_search_chk #(
    .NUM_OSC  (NUM_OSC),
    .SUBBANDS (SUBBANDS),
    .OSC_W    (OSC_W),
    .SUB_W    (SUB_W),
    .DIV_W    (DIV_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .busy      (busy_w),
    .start_i   (start_i),
    .osc_sel_o (osc_sel_o),
    .sub_sel_o (sub_sel_o),
    .div_sel_o (div_sel_o),
    .done_o    (done_o),
    .locked_o  (locked_o),
    .fail_o    (fail_o)
);

// File: tb/vco_band_search_tb.sv
module vco_band_search_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [4:0]  start_idx_i = '0;
    logic [15:0] settle_cycles_i = '0;
    logic [1:0]  div_sel_i = '0;
    logic [2:0]  lock_code_i;
    logic [1:0]  osc_sel_o;
    logic [2:0]  sub_sel_o;
    logic [1:0]  div_sel_o;
    logic        done_o, locked_o, fail_o;

    int n_checks = 0;
    int n_errors = 0;

    // plant model: 0 window around target, 1 always high, 2 always low, 3 split
    int mode = 0;
    int target = 0;
    int idx_obs;

    always #4 clk = ~clk;

    vco_band_search u_dut (
        .clk (clk), .rst_n (rst_n), .start_i (start_i), .start_idx_i (start_idx_i),
        .settle_cycles_i (settle_cycles_i), .div_sel_i (div_sel_i),
        .lock_code_i (lock_code_i), .osc_sel_o (osc_sel_o), .sub_sel_o (sub_sel_o),
        .div_sel_o (div_sel_o), .done_o (done_o), .locked_o (locked_o), .fail_o (fail_o)
    );

    assign idx_obs = int'(osc_sel_o) * 8 + int'(sub_sel_o);

    always_comb begin
        case (mode)
            0: lock_code_i = (idx_obs < target) ? 3'b111 : (idx_obs > target) ? 3'b000 : 3'b011;
            1: lock_code_i = 3'b111;
            2: lock_code_i = 3'b000;
            default: lock_code_i = (idx_obs <= target) ? 3'b111 : 3'b000;
        endcase
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic run_search(input string name, input int sidx, input int n,
                              input logic [1:0] div, input int m, input int tgt,
                              input int decisions, input int exp_idx,
                              input bit exp_lock, input bit exp_fail, input int inject_at);
        int cyc = 0;
        int sidx_c;
        sidx_c = (sidx > 23) ? 23 : sidx;
        @(negedge clk);
        mode = m; target = tgt;
        start_idx_i = 5'(sidx); settle_cycles_i = 16'(n); div_sel_i = div;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        div_sel_i = ~div;
        // R2: start setting visible one cycle after the start edge, flags cleared
        check(idx_obs == sidx_c, {name, " R2 start index"}, idx_obs, sidx_c);
        check(!locked_o && !fail_o, {name, " R2 flags cleared"}, {locked_o, fail_o}, 0);
        while (!done_o && cyc < 1000) begin
            if (inject_at >= 0 && cyc == inject_at) begin
                start_idx_i = 5'd20; start_i = 1'b1;
            end else begin
                start_i = 1'b0;
            end
            @(negedge clk);
            cyc++;
        end
        start_i = 1'b0;
        if (cyc >= 1000) check(1'b0, {name, " watchdog"}, cyc, decisions * (n + 1));
        // R4: decision timing
        check(cyc == decisions * (n + 1), {name, " R4 cycles to done"}, cyc, decisions * (n + 1));
        // R3: final setting mapping
        check(int'(osc_sel_o) == exp_idx / 8 && int'(sub_sel_o) == exp_idx % 8,
              {name, " R3 final osc/sub"}, idx_obs, exp_idx);
        check(locked_o == exp_lock, {name, " R5 locked"}, locked_o, exp_lock);
        check(fail_o == exp_fail, {name, " R8 fail"}, fail_o, exp_fail);
        check(div_sel_o == div, {name, " R12 div held"}, div_sel_o, div);
        @(negedge clk);
        // R10: one-cycle done, flags held
        check(!done_o, {name, " R10 done pulse"}, done_o, 0);
        check(locked_o == exp_lock && fail_o == exp_fail, {name, " R10 flags held"},
              {locked_o, fail_o}, {exp_lock, exp_fail});
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check(!done_o && !locked_o && !fail_o, "R1 flags", {done_o, locked_o, fail_o}, 0);
        check(idx_obs == 0 && div_sel_o == 2'b00, "R1 index/div", idx_obs, 0);
        rst_n = 1'b1;
        run_search("lock_now",  5,  0, 2'b01, 0, 5,  1,  5,  1'b1, 1'b0, -1); // R5
        run_search("up_R7",     3,  2, 2'b10, 0, 10, 8,  10, 1'b1, 1'b0, -1); // R7
        run_search("down_R6",   20, 5, 2'b11, 0, 9,  12, 9,  1'b1, 1'b0, -1); // R6
        run_search("top_R8",    22, 1, 2'b00, 1, 0,  2,  23, 1'b0, 1'b1, -1); // R8
        run_search("bottom_R8", 1,  3, 2'b01, 2, 0,  2,  0,  1'b0, 1'b1, -1); // R8
        run_search("rev_R9",    12, 0, 2'b10, 3, 12, 2,  13, 1'b0, 1'b1, -1); // R9
        run_search("busy_R11",  2,  4, 2'b11, 0, 6,  5,  6,  1'b1, 1'b0, 3);  // R11
        run_search("clamp_R2",  30, 0, 2'b00, 0, 23, 1,  23, 1'b1, 1'b0, -1); // R2
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule